// File: doc/BRIEF.md
# Branch Direction Predictor with Group-Shared Confidence

This block predicts whether a conditional branch is taken. It uses a table that is indexed by a slice of the branch address. Each table entry holds one direction bit. A single strong/weak confidence bit serves a small group of adjacent entries. Together, an entry's direction bit and its group's confidence bit behave like a two-bit saturating counter. Because the confidence bits are pooled, a table of a given size costs less storage than one with a private two-bit counter per entry. Equally, the same storage holds more branches. The pooling rests on the observation that almost every entry spends its life at strong confidence.

A lookup presents a branch address. The predicted direction and the group confidence come back combinationally in the same cycle. When a branch resolves, the execution side presents its address and actual outcome on the update port. On the next clock edge the block adjusts the entry's direction bit and the group's confidence bit, following the two-bit rules.

Top module: `bimodal_shared_hyst`

## Requirements
- R1: While rst_ni is low, every direction bit reads not-taken (0) and every confidence bit reads weak (0). The clear is asynchronous and is visible at the outputs without a clock edge.
- R2: The entry index is `pc[PC_SHIFT +: IDX_W]`, which is bits 11:2 at the defaults. Address bits below and above that slice do not affect the selected entry.
- R3: The confidence bit of entry i is the bit at `i >> log2(GRP_SIZE)`. With the default of 4, entries 4..7 share group 1. All entries of a group report the same `pred_strong_o`.
- R4: An update whose outcome equals the stored direction sets the group confidence to strong (1). The direction bit is unchanged. An update that finds the group already strong leaves it strong.
- R5: An update whose outcome differs from the stored direction while the group is strong clears the group to weak. The direction bit is unchanged.
- R6: An update whose outcome differs from the stored direction while the group is weak sets the direction bit to the outcome. The group stays weak.
- R7: `pred_taken_o` and `pred_strong_o` follow `lkp_pc_i` in the same cycle. A lookup that selects the entry being updated in the same cycle sees the old state. The new state is visible after the clock edge.
- R8: When `upd_valid_i` is low, no state changes, whatever `upd_pc_i` and `upd_taken_i` carry.
- R9: An update changes only its own entry's direction bit and its own group's confidence bit.
- R10: `pred_taken_o` is 1 for taken. `pred_strong_o` is 1 for strong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_pc_i | input | PC_W | Branch address to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_strong_o | output | 1 | Confidence of the entry's group, 1 = strong |
| upd_valid_i | input | 1 | Resolved outcome present this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench first trains a single entry repeatedly with both outcomes. This separates the strengthen, weaken and flip transitions. It then alternates outcomes on two entries of one group, which shows that a misprediction on one entry changes its neighbour's confidence but not its neighbour's direction. Addresses that differ only outside the index slice confirm aliasing, and a lookup held on the entry being written separates old from new state. A long pseudo-random address and outcome stream, confined to a few groups, is compared against a bench-side model, with the targeted entry, its group neighbour and the next group checked after every update.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_STRENGTHEN,
    ACT_WEAKEN,
    ACT_FLIP
  } upd_act_e;
endpackage

// File: rtl/bps_index.sv
module bps_index #(
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  parameter int IDX_W    = 10,
  parameter int GRP_SIZE = 4,
  localparam int GRP_W   = $clog2(GRP_SIZE),
  localparam int CONF_W  = IDX_W - GRP_W
) (
  input  logic [PC_W-1:0]   pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CONF_W-1:0] grp_o
);
  logic pc_unused;
  assign pc_unused = ^{pc_i[PC_W-1:PC_SHIFT+IDX_W], pc_i[PC_SHIFT-1:0]};

  assign idx_o = pc_i[PC_SHIFT +: IDX_W];
  assign grp_o = idx_o[IDX_W-1:GRP_W];
endmodule

// File: rtl/bps_bit_array.sv
module bps_bit_array #(
  parameter int ADDR_W = 10,
  localparam int N     = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ra0_i,
  output logic              rd0_o,
  input  logic [ADDR_W-1:0] ra1_i,
  output logic              rd1_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic              wd_i,
  output logic [N-1:0]      bits_o
);
  logic [N-1:0] q;

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q[e] <= 1'b0;
      else if (we_i && (wa_i == ADDR_W'(e)))       q[e] <= wd_i;
    end
  end

  // reads return pre-edge state
  assign rd0_o  = q[ra0_i];
  assign rd1_o  = q[ra1_i];
  assign bits_o = q;
endmodule

// File: rtl/bps_update.sv
module bps_update
  import bps_pkg::*;
(
  input  logic     valid_i,
  input  logic     taken_i,
  input  logic     cur_dir_i,
  input  logic     cur_strong_i,
  output upd_act_e act_o,
  output logic     dir_we_o,
  output logic     dir_wd_o,
  output logic     conf_we_o,
  output logic     conf_wd_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (valid_i) begin
      if (cur_dir_i == taken_i) act_o = ACT_STRENGTHEN;
      else if (cur_strong_i)    act_o = ACT_WEAKEN;
      else                      act_o = ACT_FLIP;
    end
  end

  assign dir_we_o  = (act_o == ACT_FLIP);
  assign dir_wd_o  = taken_i;
  assign conf_we_o = (act_o == ACT_STRENGTHEN) || (act_o == ACT_WEAKEN);
  assign conf_wd_o = (act_o == ACT_STRENGTHEN);
endmodule

// File: rtl/bimodal_shared_hyst.sv
module bimodal_shared_hyst
  import bps_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  parameter int IDX_W    = 10,
  parameter int GRP_SIZE = 4,
  localparam int GRP_W   = $clog2(GRP_SIZE),
  localparam int CONF_W  = IDX_W - GRP_W,
  localparam int N_DIR   = 1 << IDX_W,
  localparam int N_CONF  = 1 << CONF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lkp_pc_i,
  output logic            pred_taken_o,
  output logic            pred_strong_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  logic [IDX_W-1:0]  lkp_idx, upd_idx;
  logic [CONF_W-1:0] lkp_grp, upd_grp;
  logic              upd_dir, upd_strong;
  logic              dir_we, dir_wd, conf_we, conf_wd;
  upd_act_e          upd_act;
  logic [N_DIR-1:0]  dir_vec;
  logic [N_CONF-1:0] conf_vec;

  bps_index #(.PC_W(PC_W), .PC_SHIFT(PC_SHIFT), .IDX_W(IDX_W), .GRP_SIZE(GRP_SIZE))
    u_lkp_idx (.pc_i(lkp_pc_i), .idx_o(lkp_idx), .grp_o(lkp_grp));

  bps_index #(.PC_W(PC_W), .PC_SHIFT(PC_SHIFT), .IDX_W(IDX_W), .GRP_SIZE(GRP_SIZE))
    u_upd_idx (.pc_i(upd_pc_i), .idx_o(upd_idx), .grp_o(upd_grp));

  bps_bit_array #(.ADDR_W(IDX_W)) u_dir (
    .clk_i (clk_i),   .rst_ni(rst_ni),
    .ra0_i (lkp_idx), .rd0_o (pred_taken_o),
    .ra1_i (upd_idx), .rd1_o (upd_dir),
    .we_i  (dir_we),  .wa_i  (upd_idx), .wd_i(dir_wd),
    .bits_o(dir_vec)
  );

  bps_bit_array #(.ADDR_W(CONF_W)) u_conf (
    .clk_i (clk_i),   .rst_ni(rst_ni),
    .ra0_i (lkp_grp), .rd0_o (pred_strong_o),
    .ra1_i (upd_grp), .rd1_o (upd_strong),
    .we_i  (conf_we), .wa_i  (upd_grp), .wd_i(conf_wd),
    .bits_o(conf_vec)
  );

  bps_update u_upd (
    .valid_i     (upd_valid_i),
    .taken_i     (upd_taken_i),
    .cur_dir_i   (upd_dir),
    .cur_strong_i(upd_strong),
    .act_o       (upd_act),
    .dir_we_o    (dir_we),
    .dir_wd_o    (dir_wd),
    .conf_we_o   (conf_we),
    .conf_wd_o   (conf_wd)
  );

  logic act_unused;
  assign act_unused = ^upd_act;
endmodule

// File: rtl/bimodal_shared_hyst_chk.sv
module bimodal_shared_hyst_chk #(
  parameter int IDX_W    = 10,
  parameter int GRP_SIZE = 4,
  localparam int GRP_W   = $clog2(GRP_SIZE),
  localparam int CONF_W  = IDX_W - GRP_W,
  localparam int N_DIR   = 1 << IDX_W,
  localparam int N_CONF  = 1 << CONF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic [IDX_W-1:0]  upd_idx,
  input logic [N_DIR-1:0]  dir_vec,
  input logic [N_CONF-1:0] conf_vec
);
  logic [CONF_W-1:0] ugrp;
  logic              cur_dir, cur_conf;
  assign ugrp     = upd_idx[IDX_W-1:GRP_W];
  assign cur_dir  = dir_vec[upd_idx];
  assign cur_conf = conf_vec[ugrp];

  // R1
  always @(posedge clk_i)
    if (!rst_ni) reset_clear_chk: assert (dir_vec == '0 && conf_vec == '0);

  // R4
  correct_strengthen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && cur_dir == upd_taken_i) |=>
      (conf_vec[$past(ugrp)] && dir_vec == $past(dir_vec)));

  // R5
  wrong_strong_weaken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && cur_dir != upd_taken_i && cur_conf) |=>
      (!conf_vec[$past(ugrp)] && dir_vec == $past(dir_vec)));

  // R6
  wrong_weak_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && cur_dir != upd_taken_i && !cur_conf) |=>
      (dir_vec[$past(upd_idx)] == $past(upd_taken_i) && conf_vec == $past(conf_vec)));

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> ($stable(dir_vec) && $stable(conf_vec)));

  // R9
  local_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=>
      (((dir_vec ^ $past(dir_vec)) & ~(N_DIR'(1) << $past(upd_idx))) == '0 &&
       ((conf_vec ^ $past(conf_vec)) & ~(N_CONF'(1) << $past(ugrp))) == '0));
endmodule

bind bimodal_shared_hyst bimodal_shared_hyst_chk #(.IDX_W(IDX_W), .GRP_SIZE(GRP_SIZE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_valid_i(upd_valid_i),
  .upd_taken_i(upd_taken_i),
  .upd_idx    (upd_idx),
  .dir_vec    (dir_vec),
  .conf_vec   (conf_vec)
);

// File: tb/sim_bimodal_shared_hyst.sv
`timescale 1ns/1ps
module sim_bimodal_shared_hyst;
  localparam int PC_W = 32, PC_SHIFT = 2, IDX_W = 10, GRP_SIZE = 4;
  localparam int GRP_W = 2;
  localparam int N_DIR = 1 << IDX_W, N_CONF = 1 << (IDX_W - GRP_W);

  logic clk = 1'b0, rst_ni = 1'b1;
  logic [PC_W-1:0] lkp_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pred_taken_o, pred_strong_o;

  int n_chk = 0, n_fail = 0;
  bit exp_dir [N_DIR];
  bit exp_conf[N_CONF];

  always #2 clk = ~clk;

  bimodal_shared_hyst #(.PC_W(PC_W), .PC_SHIFT(PC_SHIFT), .IDX_W(IDX_W), .GRP_SIZE(GRP_SIZE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_pc_i(lkp_pc),
    .pred_taken_o(pred_taken_o), .pred_strong_o(pred_strong_o),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken)
  );

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[PC_SHIFT +: IDX_W]);
  endfunction

  function automatic void model_clear();
    foreach (exp_dir[i])  exp_dir[i]  = 1'b0;
    foreach (exp_conf[i]) exp_conf[i] = 1'b0;
  endfunction

  function automatic void model_upd(input logic [PC_W-1:0] pc, input bit t);
    int i = idx_of(pc);
    int g = i >> GRP_W;
    if (exp_dir[i] == t)  exp_conf[g] = 1'b1;
    else if (exp_conf[g]) exp_conf[g] = 1'b0;
    else                  exp_dir[i]  = t;
  endfunction

  task automatic cmp(input string req, input logic [PC_W-1:0] pc, input bit et, input bit es);
    n_chk++;
    if (pred_taken_o !== et || pred_strong_o !== es) begin
      n_fail++;
      $display("FAIL %s pc=%h got taken=%b strong=%b exp taken=%b strong=%b",
               req, pc, pred_taken_o, pred_strong_o, et, es);
    end
  endtask

  // called just after a falling edge
  task automatic check_pc(input logic [PC_W-1:0] pc, input string req);
    lkp_pc = pc;
    #1;
    cmp(req, pc, exp_dir[idx_of(pc)], exp_conf[idx_of(pc) >> GRP_W]);
  endtask

  task automatic do_update(input logic [PC_W-1:0] pc, input bit t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    model_upd(pc, t);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_pc(32'h0000_0000, "R1 entry0");
    check_pc(32'h0000_0ffc, "R1 last entry");
    @(negedge clk);
    check_pc(32'h0000_0154, "R10 reset not-taken weak");
  endtask

  task automatic t_single_entry();
    logic [PC_W-1:0] p = 32'h0000_0014; // idx 5
    do_update(p, 1'b1); check_pc(p, "R6 flip to taken weak");
    do_update(p, 1'b1); check_pc(p, "R4 correct -> strong");
    do_update(p, 1'b1); check_pc(p, "R4 strong saturates");
    do_update(p, 1'b0); check_pc(p, "R5 wrong strong -> weak, dir kept");
    do_update(p, 1'b0); check_pc(p, "R6 wrong weak -> flip");
    do_update(p, 1'b0); check_pc(p, "R4 correct not-taken -> strong");
  endtask

  task automatic t_group_share();
    logic [PC_W-1:0] a = 32'h0000_0020; // idx 8, group 2
    logic [PC_W-1:0] b = 32'h0000_002c; // idx 11, group 2
    do_update(a, 1'b1); do_update(a, 1'b1);
    check_pc(b, "R3 neighbour sees shared strong");
    do_update(b, 1'b1);
    check_pc(b, "R5 neighbour mispredict weakens group");
    @(negedge clk);
    check_pc(a, "R3 shared weak seen by trained entry");
    @(negedge clk);
    check_pc(32'h0000_0030, "R9 next group untouched");
  endtask

  task automatic t_alias();
    logic [PC_W-1:0] p = 32'h0000_0040; // idx 16
    do_update(p | 32'h0000_0003, 1'b1);
    check_pc(p, "R2 low bits ignored on update");
    @(negedge clk);
    check_pc(p | 32'hABC0_0000, "R2 high bits alias");
    @(negedge clk);
    check_pc(32'h0000_1040, "R2 bit above slice aliases");
  endtask

  task automatic t_same_cycle();
    logic [PC_W-1:0] p = 32'h0000_0080; // idx 32
    bit od, os;
    @(negedge clk);
    od = exp_dir[idx_of(p)]; os = exp_conf[idx_of(p) >> GRP_W];
    upd_valid = 1'b1; upd_pc = p; upd_taken = ~od; lkp_pc = p;
    #1;
    cmp("R7 same-cycle lookup sees old", p, od, os);
    model_upd(p, ~od);
    @(negedge clk);
    upd_valid = 1'b0;
    check_pc(p, "R7 new state after edge");
  endtask

  task automatic t_idle();
    logic [PC_W-1:0] p = 32'h0000_0090; // idx 36
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = p; upd_taken = ~exp_dir[idx_of(p)];
    repeat (3) @(negedge clk);
    check_pc(p, "R8 invalid update ignored");
  endtask

  task automatic t_random();
    logic [15:0] lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [PC_W-1:0] p;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      p = (PC_W'(lf[4:0]) << PC_SHIFT) | (PC_W'(lf[15:11]) << 20);
      do_update(p, lf[7] | lf[8]);
      check_pc(p, "R9 random target");
      @(negedge clk);
      check_pc(p ^ 32'h4, "R9 random group neighbour");
      @(negedge clk);
      check_pc(p + 32'h10, "R9 random next group");
    end
  endtask

  task automatic t_async_reset();
    logic [PC_W-1:0] p = 32'h0000_0014;
    do_update(p, 1'b1); do_update(p, 1'b1); do_update(p, 1'b1);
    @(negedge clk);
    rst_ni = 1'b0;
    model_clear();
    check_pc(p, "R1 async clear without edge");
    @(negedge clk);
    rst_ni = 1'b1;
    check_pc(32'h0000_0080, "R1 other entry cleared");
  endtask

  bit done = 1'b0;

  initial begin
    model_clear();
    #1 rst_ni = 1'b0;
    #20 rst_ni = 1'b1;
    t_reset();
    t_single_entry();
    t_group_share();
    t_alias();
    t_same_cycle();
    t_idle();
    t_random();
    t_async_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule